// File: doc/BRIEF.md
# Block Edge Overlap Smoothing Filter

This block smooths the seam between two neighbouring 8x8 pixel blocks. Each valid cycle it takes one group of four unsigned 8-bit pixels that lie in a line across the seam. The two pixels on the near side come first, then the two on the far side, and they are named a, b, c and d in that order. The block returns four filtered pixels through a fixed asymmetric integer kernel. A single rounding-control bit moves the bias of the kernel: it lowers the bias of the outer-left and inner-right outputs and raises the bias of the other two. Each result is clamped to 0..255.

An edge is eight such groups, taken at consecutive positions along the seam. A wrapper gathers the groups from rows or from columns depending on the edge direction. The direction bit travels through the block with its group, so the wrapper knows where to write the result back. The block counts accepted groups and raises a one-cycle edge-done flag together with the eighth filtered group. Input groups may arrive back to back or with idle cycles between them.

Top module: `edge_overlap_smoother`

## Requirements
- R1: Output pixel 0 (px_out[7:0]) is the clamp of floor((7a + d + 4 - r) / 8), where a = px_in[7:0], b = px_in[15:8], c = px_in[23:16], d = px_in[31:24] and r = rnd_ctl.
- R2: Output pixel 1 (px_out[15:8]) is the clamp of floor((7b - a + c + d + 3 + r) / 8).
- R3: Output pixel 2 (px_out[23:16]) is the clamp of floor((a + b + 7c - d + 4 - r) / 8).
- R4: Output pixel 3 (px_out[31:24]) is the clamp of floor((a + 7d + 3 + r) / 8).
- R5: Negative intermediate results give 0 and results above 255 give 255; no wrap-around.
- R6: Setting rnd_ctl to 1 lowers the bias of pixels 0 and 2 by one and raises the bias of pixels 1 and 3 by one.
- R7: out_valid is high exactly one clock after a cycle with in_valid high, and px_out shows that group's result in the same cycle.
- R8: In a cycle after in_valid was low, px_out and out_dir keep their previous values.
- R9: edge_done pulses together with every eighth accepted group since reset. Idle cycles do not advance the count, and after the pulse the count restarts with the next group.
- R10: edge_done is never high while out_valid is low.
- R11: out_dir repeats the dir_horiz value that was sampled with the group now on px_out.
- R12: After reset, out_valid, edge_done, out_dir and px_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel group is presented this cycle |
| px_in | input | 32 | Pixels a, b, c, d in byte lanes 0 to 3 |
| rnd_ctl | input | 1 | Rounding-control bit |
| dir_horiz | input | 1 | Edge direction tag, carried with the group |
| out_valid | output | 1 | px_out holds a fresh result |
| px_out | output | 32 | Filtered pixels in byte lanes 0 to 3 |
| out_dir | output | 1 | Direction tag of the group on px_out |
| edge_done | output | 1 | The group on px_out is the last of an edge |

## Verification
Two things can happen in the same clock: the edge-done pulse for the eighth group of one edge, and the acceptance of the first group of the next edge. The bench provokes this by keeping in_valid high across edge boundaries. In that cycle it checks that the pulse appears only with the eighth result and that the next group's output starts a fresh count. Random idle gaps move the boundary to different cycles, and for every group the pixel values are compared against a bench model of the kernel. Directed saturating and near-zero groups are applied with both rounding settings.

// File: rtl/eos_pkg.sv
package eos_pkg;
    localparam int PIX_W    = 8;
    localparam int NUM_TAPS = 4;
    localparam int GROUPS   = 8;
    localparam int FRAC_SH  = 3;
    localparam int SUM_W    = PIX_W + 5;
    localparam int BUS_W    = PIX_W * NUM_TAPS;

    // weight of source pixel src (0=a .. 3=d) in output tap
    function automatic int tap_coef(input int tap, input int src);
        case (tap)
            0:       return (src == 0) ? 7 : (src == 3) ? 1 : 0;
            1:       return (src == 0) ? -1 : (src == 1) ? 7 : 1;
            2:       return (src == 2) ? 7 : (src == 3) ? -1 : 1;
            default: return (src == 0) ? 1 : (src == 3) ? 7 : 0;
        endcase
    endfunction

    function automatic int tap_bias(input int tap);
        return (tap == 0 || tap == 2) ? 4 : 3;
    endfunction

    function automatic bit tap_rnd_adds(input int tap);
        return (tap == 1 || tap == 3);
    endfunction

    typedef struct packed {
        logic             valid;
        logic             done;
        logic             dir;
        logic [BUS_W-1:0] px;
    } out_state_t;
endpackage

// File: rtl/eos_clamp.sv
module eos_clamp
    import eos_pkg::*;
(
    input  logic signed [SUM_W-1:0] val,
    output logic [PIX_W-1:0]        pix
);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

    always_comb begin
        if (val < 0)         pix = '0;
        else if (val > MAXV) pix = '1;
        else                 pix = val[PIX_W-1:0];
    end
endmodule

// File: rtl/eos_tap.sv
module eos_tap
    import eos_pkg::*;
#(
    parameter int TAP = 0
) (
    input  logic [BUS_W-1:0] grp,
    input  logic             rnd,
    output logic [PIX_W-1:0] pix
);
    localparam int EXT = SUM_W - PIX_W;
    localparam logic signed [SUM_W-1:0] BIAS = SUM_W'(tap_bias(TAP));
    localparam bit ADDS = tap_rnd_adds(TAP);

    logic signed [SUM_W-1:0] term [NUM_TAPS];
    logic signed [SUM_W-1:0] rnd_x;
    logic signed [SUM_W-1:0] sum_d;
    logic signed [SUM_W-1:0] shr_d;

    for (genvar s = 0; s < NUM_TAPS; s++) begin : g_term
        localparam logic signed [SUM_W-1:0] K = SUM_W'(tap_coef(TAP, s));
        assign term[s] = K * $signed({{EXT{1'b0}}, grp[s*PIX_W +: PIX_W]});
    end

    assign rnd_x = $signed({{(SUM_W-1){1'b0}}, rnd});

    always_comb begin
        sum_d = BIAS;
        for (int s = 0; s < NUM_TAPS; s++) sum_d = sum_d + term[s];
        sum_d = ADDS ? (sum_d + rnd_x) : (sum_d - rnd_x);
        shr_d = sum_d >>> FRAC_SH;
    end

    eos_clamp u_clamp (.val(shr_d), .pix(pix));
endmodule

// File: rtl/eos_grp_counter.sv
module eos_grp_counter
    import eos_pkg::*;
#(
    parameter int N = GROUPS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic last
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == LAST_IDX);

    always_comb begin
        cnt_d = cnt_q;
        if (step) cnt_d = last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: count restarts after the final group of an edge
    assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (cnt_q == '0));
    // R9: idle cycles leave the count alone
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));
endmodule

// File: rtl/edge_overlap_smoother.sv
module edge_overlap_smoother
    import eos_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      px_in,
    input  logic             rnd_ctl,
    input  logic             dir_horiz,
    output logic             out_valid,
    output logic [31:0]      px_out,
    output logic             out_dir,
    output logic             edge_done
);
    logic [BUS_W-1:0] filt;
    logic             grp_last;
    out_state_t       st_d, st_q;

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        eos_tap #(.TAP(t)) u_tap (
            .grp (px_in),
            .rnd (rnd_ctl),
            .pix (filt[t*PIX_W +: PIX_W])
        );
    end

    eos_grp_counter #(.N(GROUPS)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (in_valid),
        .last  (grp_last)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.done  = in_valid && grp_last;
        if (in_valid) begin
            st_d.px  = filt;
            st_d.dir = dir_horiz;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign edge_done = st_q.done;
    assign out_dir   = st_q.dir;
    assign px_out    = st_q.px;

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(px_out) && $stable(out_dir)));
    assert_done_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        edge_done |-> out_valid);
    assert_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dir == $past(dir_horiz)));
endmodule

// File: tb/edge_overlap_smoother_bench.sv
`timescale 1ns/1ps
module edge_overlap_smoother_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] px_in = '0;
    logic        rnd_ctl = 1'b0;
    logic        dir_horiz = 1'b0;
    logic        out_valid, out_dir, edge_done;
    logic [31:0] px_out;

    int n_chk = 0;
    int n_bad = 0;
    int accepted = 0;
    logic [31:0] last_px = '0;
    logic        last_dir = 1'b0;

    always #2.5 clk = ~clk;

    edge_overlap_smoother u_edge_overlap_smoother (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .px_in(px_in),
        .rnd_ctl(rnd_ctl), .dir_horiz(dir_horiz), .out_valid(out_valid),
        .px_out(px_out), .out_dir(out_dir), .edge_done(edge_done)
    );

    function automatic logic [7:0] sat8(input int v);
        if (v < 0) return 8'd0;
        if (v > 255) return 8'd255;
        return v[7:0];
    endfunction

    function automatic logic [31:0] model(input logic [31:0] g, input int r);
        int a, b, c, d;
        logic [31:0] y;
        a = int'(g[7:0]); b = int'(g[15:8]); c = int'(g[23:16]); d = int'(g[31:24]);
        y[7:0]   = sat8((7*a + d + 4 - r) >>> 3);
        y[15:8]  = sat8((-a + 7*b + c + d + 3 + r) >>> 3);
        y[23:16] = sat8((a + b + 7*c - d + 4 - r) >>> 3);
        y[31:24] = sat8((a + 7*d + 3 + r) >>> 3);
        return y;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check 1 ns after the capturing edge
    task automatic step(input logic v, input logic [31:0] g, input logic r, input logic dr);
        logic [31:0] exp_px;
        logic        exp_done;
        @(negedge clk);
        in_valid = v; px_in = g; rnd_ctl = r; dir_horiz = dr;
        exp_px   = v ? model(g, int'(r)) : last_px;
        exp_done = 1'b0;
        if (v) begin
            accepted++;
            exp_done = (accepted % 8 == 0);
        end
        @(posedge clk); #1;
        chk("R7 out_valid", {31'd0, out_valid}, {31'd0, v});
        chk("R9/R10 edge_done", {31'd0, edge_done}, {31'd0, exp_done});
        if (v) begin
            chk("R1-R6 px_out", px_out, exp_px);
            chk("R11 out_dir", {31'd0, out_dir}, {31'd0, dr});
            last_px = exp_px; last_dir = dr;
        end else begin
            chk("R8 px_out hold", px_out, exp_px);
            chk("R8 out_dir hold", {31'd0, out_dir}, {31'd0, last_dir});
        end
    endtask

    initial begin : watchdog
        #900000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] y;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk("R12 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R12 edge_done", {31'd0, edge_done}, 32'd0);
        chk("R12 out_dir", {31'd0, out_dir}, 32'd0);
        chk("R12 px_out", px_out, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // pure-model sanity of directed values
        y = model(32'hFF000000, 0);
        chk("R5 model low clamp pixel2", {24'd0, y[23:16]}, 32'd0);

        // directed corners, both rounding values
        for (int r = 0; r < 2; r++) begin
            step(1'b1, 32'h00000000, r[0], 1'b0);           // R1-R4 zeros
            step(1'b1, 32'hFFFFFFFF, r[0], 1'b1);           // R5 top
            step(1'b1, 32'h000000FF, r[0], 1'b0);           // R5 pixel1 negative -> 0
            step(1'b1, 32'hFF000000, r[0], 1'b1);           // R5 pixel2 negative -> 0
            step(1'b1, 32'hFFFFFF00, r[0], 1'b0);           // R5 pixel1 above 255
            step(1'b1, 32'h04000000, r[0], 1'b1);           // R6 pixel0 rounding edge
            step(1'b1, 32'h01020304, r[0], 1'b0);           // R2 R3 small values
            step(0, 32'hDEADBEEF, r[0], 1'b1);              // R8 idle
            step(1'b1, 32'h80402010, r[0], 1'b1);           // R1 R4 mixed
        end

        // R6 targeted: a=0,d=4 -> pixel0 is 1 with rnd=0 and 0 with rnd=1
        step(1'b1, 32'h04000000, 1'b0, 1'b0);
        chk("R6 pixel0 rnd0", {24'd0, px_out[7:0]}, 32'd1);
        step(1'b1, 32'h04000000, 1'b1, 1'b0);
        chk("R6 pixel0 rnd1", {24'd0, px_out[7:0]}, 32'd0);

        // random traffic with gaps; long back-to-back runs cross edge boundaries (R9)
        for (int i = 0; i < 3000; i++) begin
            logic v;
            v = (i % 500 < 100) ? 1'b1 : ($urandom_range(0, 3) != 0);
            step(v, $urandom, 1'($urandom), 1'($urandom));
        end

        @(negedge clk); in_valid = 1'b0;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule